// File: doc/BRIEF.md
# Near-Branch Direction and Target Predictor

This block sits in an instruction fetch front end and guesses, for a branch at a given instruction address, whether it will be taken and where it will go. It keeps a direct-mapped table of branch entries indexed by the low bits of the instruction address. Each entry carries a valid bit, an address tag, a target address and a 2-bit saturating direction counter. A lookup that hits the table yields a prediction without any decoded information about the instruction.

When the table misses, the block falls back on facts the decode stage presents in the same cycle: a 3-bit branch kind and a signed displacement. Conditional branches that jump backward are guessed taken and forward ones not taken. Direct jumps and calls are guessed taken to the address plus the displacement. Returns and indirect branches carry no target that can be computed, so they get no prediction on a miss. Far transfers are never predicted.

The table learns only from retired branches, through a separate retire port. A retire that hits the table adjusts the counter and rewrites the target. A retire that misses replaces whatever occupied the indexed slot. The lookup outputs are combinational on the lookup inputs and on the table registers. A retire write becomes visible on the cycle after it is presented.

Top module: `branch_predictor`

## Requirements
- R1: A lookup hits (`tbl_hit`=1) when the slot indexed by `pc[IW-1:0]` is valid and holds the tag `pc[AW-1:IW]`. On a hit with a near kind (0 to 4), `pred_valid`=1, `pred_target` is the stored target and `pred_taken` is the counter's upper bit.
- R2: On a miss with kind 0 (conditional) and a negative displacement (`disp[DW-1]`=1), the block predicts taken with target `pc` plus the sign-extended `disp`, and `pred_valid`=1.
- R3: On a miss with kind 0 and a non-negative displacement, the block predicts not taken, with `pred_valid`=1 and target `pc` plus the sign-extended `disp`.
- R4: On a miss with kind 1 (direct jump) or kind 2 (direct call), the block predicts taken, with `pred_valid`=1 and target `pc` plus the sign-extended `disp`.
- R5: On a miss with kind 3 (return) or kind 4 (indirect), `pred_valid`=0.
- R6: For kinds 5, 6 and 7 (far call or jump, interrupt return, software interrupt), `pred_valid`=0 whether or not the lookup hits. A retire of such a kind leaves the table unchanged.
- R7: A kind 3 (return) lookup that hits is predicted taken whatever its counter holds.
- R8: The table changes only through the retire port, and the retired target is stored. A lookup in the same cycle as a retire to the same slot sees the old contents. The new contents are seen from the next cycle.
- R9: A retire that hits moves the 2-bit counter up on taken and down on not taken, saturating at 3 and 0.
- R10: A retire that misses takes over the indexed slot, overwriting any previous occupant. It sets the counter to 2 (weakly taken) if the branch was taken and to 1 (weakly not taken) otherwise.
- R11: A synchronous reset (`rst`=1 at a clock edge) clears every valid bit, so all following lookups miss until the table is trained again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc | input | AW | Linear address of the instruction being looked up |
| kind | input | 3 | Decoded branch kind for the looked-up instruction |
| disp | input | DW | Signed displacement of the looked-up instruction |
| ret_valid | input | 1 | A branch retires this cycle |
| ret_pc | input | AW | Address of the retiring branch |
| ret_kind | input | 3 | Kind of the retiring branch |
| ret_taken | input | 1 | Resolved direction of the retiring branch |
| ret_target | input | AW | Resolved target of the retiring branch |
| tbl_hit | output | 1 | The lookup matched a valid table entry |
| pred_valid | output | 1 | A prediction is offered |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | AW | Predicted target address |

## Verification
The bench sweeps every kind against every displacement on an empty table. A predictor that read the sign from the wrong bit would flip the backward and forward guesses, and one that dropped the sign extension would send backward targets far ahead of the branch. It then walks one entry through a long run of outcomes, so that a counter that wrapped instead of saturating would turn a saturated taken entry into not taken. It also trains aliasing addresses into the same slot, where a design that compared no tag or kept the old occupant would return a stale target. Finally it presents a lookup and a retire to one slot in the same cycle, and retires far transfers. A write-through table would expose the new target one cycle early, and a design that trained on far kinds would start hitting on them.

// File: rtl/branch_predictor.sv
module branch_predictor #(
  parameter int AW = 32,
  parameter int IW = 6,
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] pc,
  input  logic [2:0]    kind,
  input  logic [DW-1:0] disp,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_pc,
  input  logic [2:0]    ret_kind,
  input  logic          ret_taken,
  input  logic [AW-1:0] ret_target,
  output logic          tbl_hit,
  output logic          pred_valid,
  output logic          pred_taken,
  output logic [AW-1:0] pred_target
);

  localparam int N  = 1 << IW;
  localparam int TW = AW - IW;

  localparam logic [2:0] K_COND = 3'd0;
  localparam logic [2:0] K_JMP  = 3'd1;
  localparam logic [2:0] K_CALL = 3'd2;
  localparam logic [2:0] K_RET  = 3'd3;

  logic [N-1:0]  vld;
  logic [TW-1:0] tag_q [N];
  logic [AW-1:0] tgt_q [N];
  logic [1:0]    ctr_q [N];

  logic [IW-1:0] lk_idx, rt_idx;
  logic [TW-1:0] lk_tag, rt_tag;
  logic          lk_far, rt_far, rt_hit, rt_we;
  logic [AW-1:0] static_tgt;
  logic [1:0]    rt_ctr, nxt_ctr;

  assign lk_idx = pc[IW-1:0];
  assign lk_tag = pc[AW-1:IW];
  assign rt_idx = ret_pc[IW-1:0];
  assign rt_tag = ret_pc[AW-1:IW];

  assign lk_far = kind[2] & (kind[1] | kind[0]);
  assign rt_far = ret_kind[2] & (ret_kind[1] | ret_kind[0]);

  assign tbl_hit    = vld[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign static_tgt = pc + {{(AW-DW){disp[DW-1]}}, disp};

  always_comb begin
    pred_valid  = 1'b0;
    pred_taken  = 1'b0;
    pred_target = static_tgt;
    if (tbl_hit) begin
      pred_valid  = !lk_far;
      pred_taken  = (kind == K_RET) ? 1'b1 : ctr_q[lk_idx][1];
      pred_target = tgt_q[lk_idx];
    end else begin
      case (kind)
        K_COND: begin
          pred_valid = 1'b1;
          pred_taken = disp[DW-1];
        end
        K_JMP, K_CALL: begin
          pred_valid = 1'b1;
          pred_taken = 1'b1;
        end
        default: begin
          pred_valid = 1'b0;
          pred_taken = (kind == K_RET);
        end
      endcase
    end
  end

  assign rt_we  = ret_valid && !rt_far;
  assign rt_hit = vld[rt_idx] && (tag_q[rt_idx] == rt_tag);
  assign rt_ctr = ctr_q[rt_idx];

  always_comb begin
    if (!rt_hit)
      nxt_ctr = ret_taken ? 2'd2 : 2'd1;
    else if (ret_taken)
      nxt_ctr = (rt_ctr == 2'd3) ? 2'd3 : rt_ctr + 2'd1;
    else
      nxt_ctr = (rt_ctr == 2'd0) ? 2'd0 : rt_ctr - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      vld <= '0;
    else if (rt_we)
      vld[rt_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rt_we && !rst) begin
      tag_q[rt_idx] <= rt_tag;
      tgt_q[rt_idx] <= ret_target;
      ctr_q[rt_idx] <= nxt_ctr;
    end
  end

endmodule

module branch_predictor_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] pc,
  input logic [2:0]    kind,
  input logic          ret_valid,
  input logic [AW-1:0] ret_pc,
  input logic [2:0]    ret_kind,
  input logic [AW-1:0] ret_target,
  input logic          tbl_hit,
  input logic          pred_valid,
  input logic          pred_taken,
  input logic [AW-1:0] pred_target
);

  AST_FAR_NEVER_PREDICTED: assert property (@(posedge clk) disable iff (rst)
    (kind >= 3'd5) |-> !pred_valid); // R6

  AST_RETURN_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && kind == 3'd3) |-> pred_taken); // R7

  AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !tbl_hit); // R11

  AST_RETIRE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_kind < 3'd5) |=> (pc != $past(ret_pc) || tbl_hit)); // R8

  AST_RETIRE_TARGET: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_kind < 3'd5) |=> (pc != $past(ret_pc) || pred_target == $past(ret_target))); // R8

endmodule

bind branch_predictor branch_predictor_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .pc(pc), .kind(kind),
  .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_kind(ret_kind), .ret_target(ret_target),
  .tbl_hit(tbl_hit), .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_target(pred_target)
);

// File: tb/test_branch_predictor.sv
module test_branch_predictor;
  localparam int P  = 10;
  localparam int AW = 16;
  localparam int IW = 3;
  localparam int DW = 8;
  localparam int N  = 1 << IW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] pc = '0;
  logic [2:0] kind = '0;
  logic [DW-1:0] disp = '0;
  logic ret_valid = 1'b0;
  logic [AW-1:0] ret_pc = '0;
  logic [2:0] ret_kind = '0;
  logic ret_taken = 1'b0;
  logic [AW-1:0] ret_target = '0;
  logic tbl_hit, pred_valid, pred_taken;
  logic [AW-1:0] pred_target;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic          m_v   [N];
  logic [AW-1:0] m_pc  [N];
  logic [AW-1:0] m_tgt [N];
  int            m_ctr [N];

  always #(P/2) clk = ~clk;

  branch_predictor #(.AW(AW), .IW(IW), .DW(DW)) i_branch_predictor (
    .clk(clk), .rst(rst), .pc(pc), .kind(kind), .disp(disp),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_kind(ret_kind),
    .ret_taken(ret_taken), .ret_target(ret_target),
    .tbl_hit(tbl_hit), .pred_valid(pred_valid), .pred_taken(pred_taken),
    .pred_target(pred_target)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (pc=%h kind=%0d disp=%h)", req, act, exp, pc, kind, disp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
  endtask

  // compare outputs against the model; call while inputs are settled
  task automatic expect_now(input string req);
    int i;
    logic hit, v, t;
    logic [AW-1:0] tg;
    i   = int'(pc[IW-1:0]);
    hit = m_v[i] && (m_pc[i][AW-1:IW] == pc[AW-1:IW]);
    tg  = pc + {{(AW-DW){disp[DW-1]}}, disp};
    if (hit) begin
      v  = (kind <= 3'd4);
      t  = (kind == 3'd3) ? 1'b1 : (m_ctr[i] >= 2);
      tg = m_tgt[i];
    end else begin
      v = (kind <= 3'd2);
      t = (kind == 3'd0) ? disp[DW-1] : 1'b1;
    end
    chk({req, " hit"}, AW'(tbl_hit), AW'(hit));
    chk({req, " valid"}, AW'(pred_valid), AW'(v));
    if (v) begin
      chk({req, " taken"}, AW'(pred_taken), AW'(t));
      chk({req, " target"}, pred_target, tg);
    end
  endtask

  task automatic look(input logic [AW-1:0] a, input logic [2:0] k, input logic [DW-1:0] d, input string req);
    @(negedge clk);
    pc = a; kind = k; disp = d;
    #1;
    expect_now(req);
  endtask

  task automatic model_retire(input logic [AW-1:0] a, input logic [2:0] k, input logic tk, input logic [AW-1:0] tg);
    int i;
    i = int'(a[IW-1:0]);
    if (k >= 3'd5) return;
    if (m_v[i] && m_pc[i][AW-1:IW] == a[AW-1:IW])
      m_ctr[i] = tk ? ((m_ctr[i] == 3) ? 3 : m_ctr[i] + 1) : ((m_ctr[i] == 0) ? 0 : m_ctr[i] - 1);
    else
      m_ctr[i] = tk ? 2 : 1;
    m_v[i] = 1'b1; m_pc[i] = a; m_tgt[i] = tg;
  endtask

  task automatic retire(input logic [AW-1:0] a, input logic [2:0] k, input logic tk, input logic [AW-1:0] tg);
    @(negedge clk);
    ret_valid = 1'b1; ret_pc = a; ret_kind = k; ret_taken = tk; ret_target = tg;
    @(posedge clk);
    #1;
    ret_valid = 1'b0;
    model_retire(a, k, tk, tg);
  endtask

  initial begin
    #(P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R11 reset state, then R2 R3 R4 R5 R6 sweep on an empty table
    look(16'h0040, 3'd0, 8'h00, "R11");
    for (int k = 0; k < 8; k++)
      for (int d = 0; d < 256; d++)
        look(16'h1000 + 16'(d * 37), 3'(k), 8'(d),
             (k == 0) ? (d >= 128 ? "R2" : "R3") : (k <= 2 ? "R4" : (k <= 4 ? "R5" : "R6")));

    // R1 R10: train every slot, alternating direction, then look up with every kind
    for (int i = 0; i < N; i++)
      retire(16'((i + 5) << IW) | 16'(i), 3'd0, 1'(i % 2), 16'hA000 + 16'(i * 16));
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 8; k++)
        look(16'((i + 5) << IW) | 16'(i), 3'(k), 8'h05, (k == 3) ? "R7" : (k >= 5 ? "R6" : "R1"));

    // R9 saturating counter walk on slot 2
    begin
      logic [AW-1:0] a;
      bit seq [14] = '{1,1,1,0,0,0,0,0,1,1,0,1,1,1};
      a = 16'((2 + 5) << IW) | 16'd2;
      foreach (seq[j]) begin
        retire(a, 3'd0, seq[j], 16'hB000 + 16'(j));
        look(a, 3'd0, 8'h00, "R9");
        look(a, 3'd3, 8'h00, "R7");
      end
    end

    // R10 aliasing overwrite: new tag takes the slot, old address misses
    retire(16'h0F04, 3'd0, 1'b0, 16'hC123);
    look(16'h0F04, 3'd0, 8'h10, "R10");
    look(16'((4 + 5) << IW) | 16'd4, 3'd0, 8'hF0, "R10");
    look(16'((4 + 5) << IW) | 16'd4, 3'd1, 8'h10, "R10");

    // R6 far retire leaves table unchanged
    for (int k = 5; k < 8; k++) begin
      retire(16'h3306, 3'(k), 1'b1, 16'hDDDD);
      look(16'h3306, 3'd0, 8'h02, "R6");
      look(16'h3306, 3'd1, 8'h02, "R6");
    end

    // R8 same-cycle lookup and retire: old contents now, new next cycle
    @(negedge clk);
    pc = 16'h0F04; kind = 3'd0; disp = 8'h00;
    ret_valid = 1'b1; ret_pc = 16'h0F04; ret_kind = 3'd1; ret_taken = 1'b1; ret_target = 16'hE0E0;
    #1;
    expect_now("R8");
    @(posedge clk);
    #1;
    ret_valid = 1'b0;
    model_retire(16'h0F04, 3'd1, 1'b1, 16'hE0E0);
    @(negedge clk);
    #1;
    expect_now("R8");
    chk("R8 target", pred_target, 16'hE0E0);

    // R8 a lookup alone never trains
    look(16'h5501, 3'd1, 8'h08, "R8");
    look(16'h5501, 3'd1, 8'h08, "R8");

    // R11 reset clears a trained table
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    model_clear();
    for (int i = 0; i < N; i++)
      look(16'((i + 5) << IW) | 16'(i), 3'd0, 8'h81, "R11");
    look(16'h0F04, 3'd0, 8'h01, "R11");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule